// File: doc/BRIEF.md
# LPC Memory Cycle Host

This block is the host side of a Low Pin Count bus. Each request produces one single-byte memory cycle. A request is one clock of `req_start`, taken together with a direction bit, a 32-bit address and a write byte. The block then runs the cycle on the bus:

- the start nibble with the frame strobe low;
- the cycle-type nibble;
- the address, high nibble first;
- for writes, the data byte, low nibble first;
- a two-clock handoff of the bus to the target.

After the handoff the host listens for the target's ready code. A read then collects the byte that follows, low nibble first. The cycle ends after the target hands the bus back. The block then gives a one-clock `rsp_done`, with the read byte on `rsp_rdata`.

If the ready code does not arrive within `SYNC_TIMEOUT` sampled clocks, the cycle is abandoned. The block raises `rsp_err` together with `rsp_done` and goes straight back to idle. The bidirectional nibble bus is split into a driven value, an output enable and a sampled input, so the pad can sit outside this block. All bus fields are launched and sampled on the rising clock edge.

Top module: `lpc_mem_host`

## Requirements
- R1: The cycle begins on the clock after the request is accepted. In its first clock, `lpc_frame_n` is low for exactly that one clock, with `lpc_lad_oe`=1 and `lpc_lad_o`=4'b0000.
- R2: The clock after the start nibble carries the cycle-type nibble with `lpc_frame_n` high: 4'b0100 for a read and 4'b0110 for a write (bit 1 is the direction, bit 0 is driven 0).
- R3: The next 8 clocks carry the 32-bit address, one nibble per clock, bits 31:28 first and bits 3:0 last.
- R4: For a write, the 2 clocks after the address carry the data byte: bits 3:0 first, then bits 7:4.
- R5: After its last field, the host drives 4'b1111 for one clock and then releases the bus (`lpc_lad_oe`=0) from the next clock on. It keeps the bus released through the ready-code wait, the read data and the target's two handback clocks.
- R6: In the ready-code wait, any sampled nibble other than 4'b0000 is treated as "keep waiting". A 4'b0000 seen within the first `SYNC_TIMEOUT` sampled clocks lets the cycle go on.
- R7: On a read, the host samples the data low nibble in the clock after the ready code and the high nibble in the next clock. The byte is on `rsp_rdata` when `rsp_done` is high and holds until the next read captures data or a timeout occurs.
- R8: If `SYNC_TIMEOUT` sampled clocks pass without 4'b0000, the host pulses `rsp_done` with `rsp_err`=1 and clears `rsp_rdata` to 0. It then returns to idle with the bus released and `lpc_frame_n` high.
- R9: After the target's two handback clocks, `rsp_done` is high for exactly one clock, with `rsp_err`=0 for a completed cycle.
- R10: `req_start` is ignored while a cycle is in progress. A request is accepted in any idle clock, including the clock in which `rsp_done` is high.
- R11: After reset, `lpc_frame_n`=1, `lpc_lad_oe`=0, `rsp_done`=0 and `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; fields launch and are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-clock request strobe, honoured only while idle |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_addr | input | 32 | Byte address of the cycle |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Byte returned by the last read |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| rsp_err | output | 1 | High with `rsp_done` when the ready code timed out |
| lpc_frame_n | output | 1 | Active-low frame strobe |
| lpc_lad_o | output | 4 | Nibble driven onto the bus |
| lpc_lad_oe | output | 1 | Drive enable for `lpc_lad_o` |
| lpc_lad_i | input | 4 | Nibble sampled from the bus |

## Verification
The assertions assume a few things about the environment:
- `req_start` comes from a well-behaved requester.
- The target never needs the host to drive during the turnaround.
- A 4'b1111 nibble is what the host drives in the clock before it lets go of the bus.

The bench plays the target as a bus model that reacts only to what the host puts on the bus, counted in clocks. It inserts a chosen number of wait nibbles (0110) before the ready code. The chosen counts are zero, a mid value, one below the timeout limit, and a count that forces the timeout. Between cycles the bench holds the bus input at 1111. It pulses `req_start` mid-cycle only to probe R10.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_START,
        PH_CTYPE,
        PH_ADDR,
        PH_WDATA,
        PH_HTAR0,
        PH_HTAR1,
        PH_SYNC,
        PH_RDATA,
        PH_TTAR0,
        PH_TTAR1
    } lpc_phase_e;

    typedef struct packed {
        logic       frame_n;
        logic       oe;
        logic [3:0] lad;
    } lpc_drive_t;

    localparam logic [3:0] NIB_START   = 4'b0000;
    localparam logic [3:0] NIB_TURN    = 4'b1111;
    localparam logic [3:0] NIB_READY   = 4'b0000;
    localparam logic [1:0] CT_MEMORY   = 2'b01;

    function automatic logic [3:0] ctype_nibble(input logic is_write);
        return {CT_MEMORY, is_write, 1'b0};
    endfunction

    function automatic lpc_drive_t released();
        lpc_drive_t d;
        d.frame_n = 1'b1;
        d.oe      = 1'b0;
        d.lad     = NIB_TURN;
        return d;
    endfunction

endpackage

// File: rtl/lpc_sync_timer.sv
module lpc_sync_timer #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // high on the final allowed sample of the wait window
    assign last = run && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/lpc_rd_assembler.sv
module lpc_rd_assembler #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [3:0]        lad_in,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DATA_NIB = DATA_W / 4;

    logic [3:0] nib_q [DATA_NIB];

    for (genvar g = 0; g < DATA_NIB; g++) begin : g_nib
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                nib_q[g] <= '0;
            end else if (cap_en && cap_idx == IDX_W'(g)) begin
                nib_q[g] <= lad_in;
            end
        end
        // nibble g arrives g-th, so low nibble first
        assign rdata[4*g +: 4] = nib_q[g];
    end

endmodule

// File: rtl/lpc_field_drive.sv
module lpc_field_drive
    import lpc_host_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  lpc_phase_e        phase,
    input  logic [IDX_W-1:0]  idx,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output lpc_drive_t        drv
);
    localparam int unsigned ADDR_NIB = ADDR_W / 4;
    localparam int unsigned DATA_NIB = DATA_W / 4;

    logic [3:0] addr_nib [ADDR_NIB];
    logic [3:0] data_nib [DATA_NIB];

    // address leaves most significant nibble first
    for (genvar g = 0; g < ADDR_NIB; g++) begin : g_addr
        assign addr_nib[g] = addr[ADDR_W-1-4*g -: 4];
    end

    // write data leaves least significant nibble first
    for (genvar g = 0; g < DATA_NIB; g++) begin : g_data
        assign data_nib[g] = wdata[4*g +: 4];
    end

    logic [3:0] addr_sel;
    logic [3:0] data_sel;

    always_comb begin
        addr_sel = addr_nib[0];
        for (int i = 0; i < ADDR_NIB; i++) begin
            if (idx == IDX_W'(i)) addr_sel = addr_nib[i];
        end
        data_sel = data_nib[0];
        for (int i = 0; i < DATA_NIB; i++) begin
            if (idx == IDX_W'(i)) data_sel = data_nib[i];
        end
    end

    always_comb begin
        drv = released();
        unique case (phase)
            PH_START: begin
                drv.frame_n = 1'b0;
                drv.oe      = 1'b1;
                drv.lad     = NIB_START;
            end
            PH_CTYPE: begin
                drv.oe  = 1'b1;
                drv.lad = ctype_nibble(is_write);
            end
            PH_ADDR: begin
                drv.oe  = 1'b1;
                drv.lad = addr_sel;
            end
            PH_WDATA: begin
                drv.oe  = 1'b1;
                drv.lad = data_sel;
            end
            PH_HTAR0: begin
                drv.oe  = 1'b1;
                drv.lad = NIB_TURN;
            end
            default: drv = released();
        endcase
    end

endmodule

// File: rtl/lpc_host_seq.sv
module lpc_host_seq
    import lpc_host_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [3:0]        lad_in,
    input  logic              wait_last,
    output lpc_phase_e        phase,
    output logic [IDX_W-1:0]  idx,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              wait_run,
    output logic              cap_en,
    output logic              sync_fail,
    output logic              done,
    output logic              err
);
    localparam int unsigned ADDR_NIB = ADDR_W / 4;
    localparam int unsigned DATA_NIB = DATA_W / 4;
    localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_NIB - 1);
    localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_NIB - 1);

    logic ready_seen;

    assign ready_seen = (lad_in == NIB_READY);
    assign wait_run   = (phase == PH_SYNC);
    assign cap_en     = (phase == PH_RDATA);
    assign sync_fail  = wait_run && !ready_seen && wait_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            idx     <= '0;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_start) begin
                        write_q <= req_write;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        phase   <= PH_START;
                    end
                end
                PH_START: phase <= PH_CTYPE;
                PH_CTYPE: begin
                    idx   <= '0;
                    phase <= PH_ADDR;
                end
                PH_ADDR: begin
                    if (idx == ADDR_LAST) begin
                        idx   <= '0;
                        phase <= write_q ? PH_WDATA : PH_HTAR0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_WDATA: begin
                    if (idx == DATA_LAST) begin
                        idx   <= '0;
                        phase <= PH_HTAR0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_HTAR0: phase <= PH_HTAR1;
                PH_HTAR1: phase <= PH_SYNC;
                PH_SYNC: begin
                    if (ready_seen) begin
                        idx   <= '0;
                        phase <= write_q ? PH_TTAR0 : PH_RDATA;
                    end else if (wait_last) begin
                        done  <= 1'b1;
                        err   <= 1'b1;
                        phase <= PH_IDLE;
                    end
                end
                PH_RDATA: begin
                    if (idx == DATA_LAST) begin
                        idx   <= '0;
                        phase <= PH_TTAR0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_TTAR0: phase <= PH_TTAR1;
                PH_TTAR1: begin
                    done  <= 1'b1;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lpc_mem_host.sv
module lpc_mem_host
    import lpc_host_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned SYNC_TIMEOUT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic              lpc_frame_n,
    output logic [3:0]        lpc_lad_o,
    output logic              lpc_lad_oe,
    input  logic [3:0]        lpc_lad_i
);
    localparam int unsigned ADDR_NIB = ADDR_W / 4;
    localparam int unsigned IDX_W    = (ADDR_NIB < 2) ? 1 : $clog2(ADDR_NIB);

    lpc_phase_e        phase;
    logic [IDX_W-1:0]  idx;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wait_run;
    logic              wait_last;
    logic              cap_en;
    logic              sync_fail;
    lpc_drive_t        drv;

    lpc_host_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_start (req_start),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .lad_in    (lpc_lad_i),
        .wait_last (wait_last),
        .phase     (phase),
        .idx       (idx),
        .write_q   (write_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .wait_run  (wait_run),
        .cap_en    (cap_en),
        .sync_fail (sync_fail),
        .done      (rsp_done),
        .err       (rsp_err)
    );

    lpc_sync_timer #(.LIMIT(SYNC_TIMEOUT)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (wait_run),
        .last (wait_last)
    );

    lpc_rd_assembler #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .clr     (sync_fail),
        .cap_en  (cap_en),
        .cap_idx (idx),
        .lad_in  (lpc_lad_i),
        .rdata   (rsp_rdata)
    );

    lpc_field_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_drv (
        .phase    (phase),
        .idx      (idx),
        .is_write (write_q),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .drv      (drv)
    );

    assign lpc_frame_n = drv.frame_n;
    assign lpc_lad_o   = drv.lad;
    assign lpc_lad_oe  = drv.oe;

endmodule

// File: rtl/lpc_mem_host_chk.sv
module lpc_mem_host_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_n,
    input logic [3:0] lad_o,
    input logic       lad_oe,
    input logic       done,
    input logic       err
);
    AST_FRAME_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst) $fell(frame_n) |=> frame_n); // R1
    AST_FRAME_WITH_START: assert property (@(posedge clk) disable iff (rst) !frame_n |-> (lad_oe && lad_o == 4'b0000)); // R1
    AST_RELEASE_AFTER_ONES: assert property (@(posedge clk) disable iff (rst) $fell(lad_oe) |-> $past(lad_o) == 4'b1111); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (rst) err |-> done); // R8
    AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst) done |-> (frame_n && !lad_oe)); // R8
endmodule

bind lpc_mem_host lpc_mem_host_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .frame_n (lpc_frame_n),
    .lad_o   (lpc_lad_o),
    .lad_oe  (lpc_lad_oe),
    .done    (rsp_done),
    .err     (rsp_err)
);

// File: tb/tb_lpc_mem_host.sv
module tb_lpc_mem_host;
    localparam int TO = 8;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic        rsp_err;
    logic        lpc_frame_n;
    logic [3:0]  lpc_lad_o;
    logic        lpc_lad_oe;
    logic [3:0]  lpc_lad_i = 4'hF;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        bit         err;
        bit         chk_data;
        logic [7:0] data;
    } exp_t;
    exp_t exp_q[$];

    lpc_mem_host #(.SYNC_TIMEOUT(TO)) dut (
        .clk (clk), .rst (rst),
        .req_start (req_start), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata), .rsp_done (rsp_done), .rsp_err (rsp_err),
        .lpc_frame_n (lpc_frame_n), .lpc_lad_o (lpc_lad_o),
        .lpc_lad_oe (lpc_lad_oe), .lpc_lad_i (lpc_lad_i)
    );

    always #HALF clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pops the scoreboard when the cycle ends
    bit prev_done = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_done && prev_done) chk(0, "R9 done longer than one clock", 1, 0);
            if (rsp_done) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R10 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rsp_err == e.err, e.err ? "R8 err flag" : "R9 err flag", 32'(rsp_err), 32'(e.err));
                    if (e.chk_data)
                        chk(rsp_rdata == e.data, e.err ? "R8 rdata cleared" : "R7 read byte", 32'(rsp_rdata), 32'(e.data));
                end
            end
            prev_done = rsp_done;
        end
    end

    // driver plus target bus model; waits = wait nibbles before ready code
    task automatic run_cycle(input bit wr, input logic [31:0] addr, input logic [7:0] wd,
                             input logic [7:0] rd, input int waits, input bit poke);
        exp_t e;
        bit   tmo;
        tmo = (waits >= TO);
        e.err = tmo;
        e.chk_data = tmo || !wr;
        e.data = tmo ? 8'h00 : rd;
        exp_q.push_back(e);
        @(negedge clk);
        req_start = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_start = 1'b0;
        chk(!lpc_frame_n && lpc_lad_oe && lpc_lad_o == 4'h0, "R1 start field",
            {27'd0, lpc_frame_n, lpc_lad_oe, lpc_lad_o}, {27'd0, 1'b0, 1'b1, 4'h0});
        @(negedge clk);
        chk(lpc_frame_n && lpc_lad_oe && lpc_lad_o == {2'b01, wr, 1'b0}, "R2 cycle type",
            32'(lpc_lad_o), 32'({2'b01, wr, 1'b0}));
        if (poke) begin
            req_start = 1'b1; req_write = ~wr; req_addr = ~addr;
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            req_start = 1'b0;
            chk(lpc_lad_oe && lpc_frame_n && lpc_lad_o == addr[31-4*i -: 4], "R3 address nibble",
                32'(lpc_lad_o), 32'(addr[31-4*i -: 4]));
        end
        if (wr) begin
            for (int i = 0; i < 2; i++) begin
                @(negedge clk);
                chk(lpc_lad_oe && lpc_lad_o == wd[4*i +: 4], "R4 write nibble",
                    32'(lpc_lad_o), 32'(wd[4*i +: 4]));
            end
        end
        @(negedge clk);
        chk(lpc_lad_oe && lpc_lad_o == 4'hF, "R5 host turnaround ones", 32'(lpc_lad_o), 32'hF);
        @(negedge clk);
        chk(!lpc_lad_oe, "R5 host releases bus", 32'(lpc_lad_oe), 0);
        for (int w = 0; w < (tmo ? TO : waits); w++) begin
            @(negedge clk);
            lpc_lad_i = 4'b0110;
            chk(!lpc_lad_oe, "R6 floating during wait", 32'(lpc_lad_oe), 0);
        end
        if (tmo) begin
            @(negedge clk);
            lpc_lad_i = 4'hF;
            for (int k = 0; k < 4; k++) begin
                chk(lpc_frame_n && !lpc_lad_oe, "R8 idle after timeout",
                    {30'd0, lpc_frame_n, lpc_lad_oe}, 32'h2);
                @(negedge clk);
            end
        end else begin
            @(negedge clk);
            lpc_lad_i = 4'b0000;
            if (!wr) begin
                @(negedge clk); lpc_lad_i = rd[3:0];
                @(negedge clk); lpc_lad_i = rd[7:4];
            end
            @(negedge clk); lpc_lad_i = 4'hF;
            chk(!lpc_lad_oe, "R5 released in handback 0", 32'(lpc_lad_oe), 0);
            @(negedge clk); lpc_lad_i = 4'hF;
            chk(!lpc_lad_oe && lpc_frame_n, "R5 released in handback 1", 32'(lpc_lad_oe), 0);
            chk(!rsp_done, "R9 no done before handback ends", 32'(rsp_done), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(lpc_frame_n && !lpc_lad_oe && !rsp_done && !rsp_err, "R11 reset state",
            {28'd0, lpc_frame_n, lpc_lad_oe, rsp_done, rsp_err}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        chk(lpc_frame_n && !lpc_lad_oe, "R11 idle after reset", {31'd0, lpc_frame_n}, 1);

        run_cycle(0, 32'hFFC0_1234, 8'h00, 8'hA5, 0, 0);
        run_cycle(1, 32'hFFBF_0008, 8'h3C, 8'h00, 0, 0);   // back-to-back, R10
        run_cycle(0, 32'h000E_F00D, 8'h00, 8'h69, 3, 0);   // R6
        run_cycle(0, 32'h8765_4321, 8'h00, 8'hF0, TO-1, 0); // R6 boundary
        run_cycle(0, 32'h1357_9BDF, 8'h00, 8'h11, TO, 0);   // R8 timeout
        run_cycle(1, 32'hFE40_0000, 8'hE7, 8'h00, TO, 0);   // R8 on write
        run_cycle(0, 32'hFFFF_FFFF, 8'h00, 8'h0F, 1, 1);    // R10 poke mid-cycle
        repeat (2) @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            chk(lpc_frame_n && !lpc_lad_oe, "R10 no cycle from ignored start",
                {30'd0, lpc_frame_n, lpc_lad_oe}, 32'h2);
            @(negedge clk);
        end
        run_cycle(1, 32'h0000_0000, 8'h5A, 8'h00, 2, 0);
        repeat (3) @(negedge clk);
        chk(rsp_rdata == 8'h0F, "R7 rdata held over write", 32'(rsp_rdata), 32'h0F);
        chk(exp_q.size() == 0, "R9 every cycle completed", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(HALF * 2 * 200000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule